// File: doc/BRIEF.md
# On-Screen-Display RAM Write Decoder

This block sits behind a SPI slave byte shifter and turns the received byte stream into single-cycle writes to an on-screen-display RAM. The RAM is addressed by a 4-bit row number and a 5-bit column number. The top bits of each byte mark it as a row address or a column address. Once an address has been set up, the next byte is display information and is written to the RAM.

Three transfer styles are supported. In the single-write style, every write sends its own row, column and data. In the same-row style, the row is kept and only column and data are sent. In the streaming style, one row and one column are sent, and every later byte is data written at an address that advances by itself. Only the cells the display really uses ever see a write strobe. These are the text area, the two per-row control cells, and the window/frame cells of the control row. Raising the select line returns the decoder to its starting state.

Top module: `osd_wr_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `wr_en` is low. After reset the decoder waits for a row address.
- R2: In address position, a byte with bit 7 = 1 is a row address. Its bits 3..0 give the row, and bits 6..4 have no effect on the written address.
- R3: In address position, a byte with bit 7 = 0 is a column address. Its bits 4..0 give the column, and bit 5 has no effect. When bit 6 = 0, exactly the next byte is taken as information.
- R4: An information byte that follows row then column produces a write at that row and column. After it, the decoder again expects a row or a column address.
- R5: A column address sent right after an information byte keeps the row last given.
- R6: A column address with bit 6 = 1 starts streaming. Every later byte, including bytes with bit 7 set, is written as information, and the column rises by one after each byte.
- R7: In streaming, a byte at column 31 is followed by column 0 of the next row.
- R8: A strobe is given only for rows 0..9 with columns 0..23 or 30..31, and for row 10 with columns 0..12. Other addresses give no strobe. Streaming still advances across them.
- R9: While `cs_n` is high, no byte is decoded. Raising `cs_n` ends streaming. After that, column bytes are ignored until a row address arrives.
- R10: `wr_en` rises exactly one cycle after the clock edge that accepts the information byte. It lasts one cycle per byte, and `wr_dat` equals that byte.
- R11: Clock cycles with `byte_vld` low change nothing and give no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Slave select, low while a transaction is open |
| byte_vld | input | 1 | One-cycle strobe: a received byte is on `byte_dat` |
| byte_dat | input | 8 | Received byte |
| wr_en | output | 1 | RAM write strobe, one cycle |
| wr_row | output | 4 | RAM write row |
| wr_col | output | 5 | RAM write column |
| wr_dat | output | 8 | RAM write data |

## Verification
Single-write and same-row sequences use changing values in the don't-care bits. This shows that the address comes only from the stated fields, and that a bare column reuses the previous row. A streaming run starts at column 22 and goes through the idle columns and the control columns into the next row. That run separates the column increment, the row carry and the map gate, and a data byte with bit 7 set shows that streaming stops address decoding. Other sequences stream into row 10 past its last control cell, insert idle gaps, and drop select in mid-stream. These separate the select clear and the row-first rule from plain data handling.

// File: rtl/osd_dec_pkg.sv
package osd_dec_pkg;

  // Decoder position within a select-low transaction
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,  // waiting for the first row address
    ST_ADDR   = 2'd1,  // row or column address expected
    ST_INFO   = 2'd2,  // one information byte expected
    ST_STREAM = 2'd3   // every byte is information, address advances
  } dec_state_e;

endpackage

// File: rtl/osd_byte_class.sv
module osd_byte_class #(
  parameter int DATA_W = 8,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic              is_row_o,
  output logic              is_stream_o,
  output logic [ROW_W-1:0]  row_num_o,
  output logic [COL_W-1:0]  col_num_o,
  output logic [DATA_W-1:0] dat_o
);
  // Tag bit marks a row address; the next one down opens streaming
  localparam int TAG_BIT  = DATA_W - 1;
  localparam int STRM_BIT = DATA_W - 2;

  always_comb begin
    is_row_o    = byte_i[TAG_BIT];
    is_stream_o = byte_i[STRM_BIT];
    row_num_o   = byte_i[ROW_W-1:0];
    col_num_o   = byte_i[COL_W-1:0];
    dat_o       = byte_i;
  end
endmodule

// File: rtl/osd_addr_track.sv
module osd_addr_track
  import osd_dec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              vld_i,
  input  logic              is_row_i,
  input  logic              is_stream_i,
  input  logic [ROW_W-1:0]  row_num_i,
  input  logic [COL_W-1:0]  col_num_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              req_vld_o,
  output logic [ROW_W-1:0]  req_row_o,
  output logic [COL_W-1:0]  req_col_o,
  output logic [DATA_W-1:0] req_dat_o
);
  localparam logic [COL_W-1:0] COL_LAST = '1;
  localparam logic [COL_W-1:0] COL_ONE  = COL_W'(1);
  localparam logic [ROW_W-1:0] ROW_ONE  = ROW_W'(1);

  dec_state_e       st_q, st_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;

  always_comb begin
    st_d      = st_q;
    row_d     = row_q;
    col_d     = col_q;
    req_vld_o = 1'b0;
    if (cs_n) begin
      st_d = ST_IDLE;
    end else if (vld_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (is_row_i) begin
            row_d = row_num_i;
            st_d  = ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (is_row_i) begin
            row_d = row_num_i;
          end else begin
            col_d = col_num_i;
            st_d  = is_stream_i ? ST_STREAM : ST_INFO;
          end
        end
        ST_INFO: begin
          req_vld_o = 1'b1;
          st_d      = ST_ADDR;
        end
        ST_STREAM: begin
          req_vld_o = 1'b1;
          col_d     = col_q + COL_ONE;
          if (col_q == COL_LAST) row_d = row_q + ROW_ONE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign req_row_o = row_q;
  assign req_col_o = col_q;
  assign req_dat_o = dat_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      row_q <= '0;
      col_q <= '0;
    end else begin
      st_q  <= st_d;
      row_q <= row_d;
      col_q <= col_d;
    end
  end
endmodule

// File: rtl/osd_map_filter.sv
module osd_map_filter #(
  parameter int DATA_W      = 8,
  parameter int ROW_W       = 4,
  parameter int COL_W       = 5,
  parameter int TEXT_ROWS   = 10,
  parameter int TEXT_COLS   = 24,
  parameter int CTRL_COL_LO = 30,
  parameter int CTRL_ROW    = 10,
  parameter int CTRL_COLS   = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DATA_W-1:0] req_dat_i,
  output logic              wr_en_o,
  output logic [ROW_W-1:0]  wr_row_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic [DATA_W-1:0] wr_dat_o
);
  localparam int NROWS = 1 << ROW_W;
  localparam logic [COL_W-1:0] TXT_LIM  = COL_W'(TEXT_COLS);
  localparam logic [COL_W-1:0] CREG_LO  = COL_W'(CTRL_COL_LO);
  localparam logic [COL_W-1:0] FRM_LIM  = COL_W'(CTRL_COLS);

  logic [NROWS-1:0] row_hit;

  // One map test per row; each row picks its own column rule
  for (genvar r = 0; r < NROWS; r++) begin : g_row
    if (r < TEXT_ROWS) begin : g_text
      assign row_hit[r] = (req_col_i < TXT_LIM) || (req_col_i >= CREG_LO);
    end else if (r == CTRL_ROW) begin : g_ctrl
      assign row_hit[r] = (req_col_i < FRM_LIM);
    end else begin : g_none
      assign row_hit[r] = 1'b0;
    end
  end

  logic mapped;
  assign mapped = row_hit[req_row_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o  <= 1'b0;
      wr_row_o <= '0;
      wr_col_o <= '0;
      wr_dat_o <= '0;
    end else begin
      wr_en_o  <= req_vld_i && mapped;
      wr_row_o <= req_row_i;
      wr_col_o <= req_col_i;
      wr_dat_o <= req_dat_i;
    end
  end
endmodule

// File: rtl/osd_wr_decoder.sv
module osd_wr_decoder #(
  parameter int DATA_W      = 8,
  parameter int ROW_W       = 4,
  parameter int COL_W       = 5,
  parameter int TEXT_ROWS   = 10,
  parameter int TEXT_COLS   = 24,
  parameter int CTRL_COL_LO = 30,
  parameter int CTRL_ROW    = 10,
  parameter int CTRL_COLS   = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_dat,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_dat
);
  logic              c_is_row, c_is_stream;
  logic [ROW_W-1:0]  c_row;
  logic [COL_W-1:0]  c_col;
  logic [DATA_W-1:0] c_dat;

  logic              r_vld;
  logic [ROW_W-1:0]  r_row;
  logic [COL_W-1:0]  r_col;
  logic [DATA_W-1:0] r_dat;

  osd_byte_class #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) class_i (
    .byte_i      (byte_dat),
    .is_row_o    (c_is_row),
    .is_stream_o (c_is_stream),
    .row_num_o   (c_row),
    .col_num_o   (c_col),
    .dat_o       (c_dat)
  );

  osd_addr_track #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) track_i (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .vld_i       (byte_vld),
    .is_row_i    (c_is_row),
    .is_stream_i (c_is_stream),
    .row_num_i   (c_row),
    .col_num_i   (c_col),
    .dat_i       (c_dat),
    .req_vld_o   (r_vld),
    .req_row_o   (r_row),
    .req_col_o   (r_col),
    .req_dat_o   (r_dat)
  );

  osd_map_filter #(
    .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .TEXT_ROWS(TEXT_ROWS), .TEXT_COLS(TEXT_COLS), .CTRL_COL_LO(CTRL_COL_LO),
    .CTRL_ROW(CTRL_ROW), .CTRL_COLS(CTRL_COLS)
  ) filt_i (
    .clk       (clk),
    .rst       (rst),
    .req_vld_i (r_vld),
    .req_row_i (r_row),
    .req_col_i (r_col),
    .req_dat_i (r_dat),
    .wr_en_o   (wr_en),
    .wr_row_o  (wr_row),
    .wr_col_o  (wr_col),
    .wr_dat_o  (wr_dat)
  );
endmodule

// File: rtl/osd_wr_decoder_chk.sv
module osd_wr_decoder_chk #(
  parameter int DATA_W      = 8,
  parameter int ROW_W       = 4,
  parameter int COL_W       = 5,
  parameter int TEXT_ROWS   = 10,
  parameter int TEXT_COLS   = 24,
  parameter int CTRL_COL_LO = 30,
  parameter int CTRL_ROW    = 10,
  parameter int CTRL_COLS   = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              byte_vld,
  input logic [DATA_W-1:0] byte_dat,
  input logic              wr_en,
  input logic [ROW_W-1:0]  wr_row,
  input logic [COL_W-1:0]  wr_col,
  input logic [DATA_W-1:0] wr_dat
);
  logic in_map;
  always_comb begin
    int r, c;
    r = int'(wr_row);
    c = int'(wr_col);
    in_map = (r < TEXT_ROWS && (c < TEXT_COLS || c >= CTRL_COL_LO)) ||
             (r == CTRL_ROW && c < CTRL_COLS);
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !wr_en);

  // R9
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !wr_en);

  // R8
  map_only_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> in_map);

  // R10
  data_echo_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_dat == $past(byte_dat)));

  // R11
  gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_vld) |-> !wr_en);
endmodule

bind osd_wr_decoder osd_wr_decoder_chk #(
  .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W),
  .TEXT_ROWS(TEXT_ROWS), .TEXT_COLS(TEXT_COLS), .CTRL_COL_LO(CTRL_COL_LO),
  .CTRL_ROW(CTRL_ROW), .CTRL_COLS(CTRL_COLS)
) chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
  .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_dat(wr_dat)
);

// File: tb/osd_wr_decoder_tb_top.sv
module osd_wr_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_dat = 8'h00;
  logic       wr_en;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [7:0] wr_dat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic       o_en;
  logic [3:0] o_row;
  logic [4:0] o_col;
  logic [7:0] o_dat;

  always #10 clk = ~clk;  // 50 MHz

  osd_wr_decoder dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_dat(wr_dat)
  );

  task automatic sample();
    o_en = wr_en; o_row = wr_row; o_col = wr_col; o_dat = wr_dat;
  endtask

  // Present one byte for one cycle; capture outputs one edge later
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1;
    byte_dat = b;
    @(negedge clk);
    byte_vld = 1'b0;
    byte_dat = ~b;
    sample();
  endtask

  task automatic expect_wr(input string tag, input logic [3:0] r, input logic [4:0] c,
                           input logic [7:0] d);
    n_chk++;
    if (!(o_en === 1'b1 && o_row === r && o_col === c && o_dat === d)) begin
      n_bad++;
      $display("FAIL %s: got en=%b row=%0d col=%0d dat=%h, expected en=1 row=%0d col=%0d dat=%h",
               tag, o_en, o_row, o_col, o_dat, r, c, d);
    end
  endtask

  task automatic expect_none(input string tag);
    n_chk++;
    if (o_en !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: got en=%b, expected en=0", tag, o_en);
    end
  endtask

  task automatic reselect();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    sample(); expect_none("R1 during reset");
    rst = 1'b0;
    @(negedge clk); sample(); expect_none("R1 after reset");
    cs_n = 1'b0;
    send(8'h05); expect_none("R1 column before row");
    send(8'h41); expect_none("R9 column before row");
  endtask

  task automatic t_fmt_single();
    send(8'hF3); expect_none("R2 row byte");
    send(8'h27); expect_none("R3 column byte");
    send(8'hAB); expect_wr("R4 single write", 4'd3, 5'd7, 8'hAB);
    @(negedge clk); sample(); expect_none("R10 one-cycle strobe");
    send(8'hD5); send(8'h02); send(8'h11);
    expect_wr("R2 row bits 6..4 ignored", 4'd5, 5'd2, 8'h11);
  endtask

  task automatic t_fmt_same_row();
    send(8'h24); send(8'h22); expect_wr("R5 same row", 4'd5, 5'd4, 8'h22);
    send(8'h09); send(8'h33); expect_wr("R5 same row again", 4'd5, 5'd9, 8'h33);
    send(8'h81); send(8'h00); send(8'h44);
    expect_wr("R4 back to single", 4'd1, 5'd0, 8'h44);
  endtask

  task automatic t_idle_gap();
    send(8'h06);
    @(negedge clk); byte_dat = 8'h85;
    @(negedge clk); sample(); expect_none("R11 idle cycle no write");
    @(negedge clk); byte_dat = 8'h42; sample(); expect_none("R11 idle cycle no write 2");
    send(8'h5A); expect_wr("R11 idle bytes ignored", 4'd1, 5'd6, 8'h5A);
  endtask

  task automatic t_stream_text();
    reselect();
    send(8'h82); send(8'h56);
    send(8'hA0); expect_wr("R6 stream first", 4'd2, 5'd22, 8'hA0);
    send(8'hA1); expect_wr("R6 stream increment", 4'd2, 5'd23, 8'hA1);
    for (int i = 0; i < 6; i++) begin
      send(8'hC0 + 8'(i)); expect_none("R8 unused columns");
    end
    send(8'hA2); expect_wr("R8 control column 30", 4'd2, 5'd30, 8'hA2);
    send(8'hA3); expect_wr("R8 control column 31", 4'd2, 5'd31, 8'hA3);
    send(8'hA4); expect_wr("R7 wrap to next row", 4'd3, 5'd0, 8'hA4);
    send(8'h8F); expect_wr("R6 tag bit is data", 4'd3, 5'd1, 8'h8F);
  endtask

  task automatic t_stream_ctrl();
    reselect();
    send(8'h8A); send(8'h4B);
    send(8'h10); expect_wr("R8 control row col 11", 4'd10, 5'd11, 8'h10);
    send(8'h11); expect_wr("R8 control row col 12", 4'd10, 5'd12, 8'h11);
    send(8'h12); expect_none("R8 control row col 13");
  endtask

  task automatic t_deselect_exit();
    reselect();
    send(8'h55); expect_none("R9 stream ended by select");
    send(8'h83); send(8'h01); send(8'h66);
    expect_wr("R9 restart after select", 4'd3, 5'd1, 8'h66);
  endtask

  task automatic t_unmapped_single();
    send(8'h8C); send(8'h03); send(8'h77); expect_none("R8 row 12 dropped");
    send(8'h84); send(8'h03); send(8'h78); expect_wr("R8 next write ok", 4'd4, 5'd3, 8'h78);
    @(negedge clk); cs_n = 1'b1;
    send(8'h99); expect_none("R9 select high ignored");
  endtask

  initial begin
    t_reset();
    t_fmt_single();
    t_fmt_same_row();
    t_idle_gap();
    t_stream_text();
    t_stream_ctrl();
    t_deselect_exit();
    t_unmapped_single();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule